// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

This block is a system watchdog. Once software turns it on, it counts down a programmable number of half-second units. Each unit is built from a slow tick-enable input, by default 16384 ticks of a 32.768 kHz enable. Software keeps the system alive by writing a two-word unlock pair to the service register, which restarts the countdown. If the countdown runs out, the block pulses an internal reset request and, if configured, an external reset output. It then records that the timeout was the cause and starts counting again.

An early-warning interrupt can be set to fire a chosen number of units before the timeout, so that software gets a last chance to act. Three mode inputs (wait, debug, low power) can each freeze counting when the matching control bit is set. The register port is a plain 16-bit write strobe with address and data, plus a combinational read mux selected by its own address. Offsets are byte addresses: control 0x0, service 0x2, reset cause 0x4, interrupt control 0x6, misc 0x8.

Top module: `guard_timer`

## Requirements
- R1: After reset, the reset-cause register (offset 0x4) reads 0x0010 (bit 4 = power-on), the control register (offset 0x0) reads 0x0000, and irq, sys_rst_req and ext_rst_out are low.
- R2: Control bit 2 is the run enable. Once it has been written as 1, it reads back 1 even after a later control write with bit 2 = 0.
- R3: The control register's bits 15:8 hold a count T. A timeout occurs after (T+1)*TICKS_PER_UNIT counted ticks, measured from the load. A load is the write that first sets the run bit, or a valid service. At a timeout, sys_rst_req is high for one cycle unless control bit 4 is 1.
- R4: At a timeout, ext_rst_out pulses for one cycle only when control bit 3 is 1 and control bit 5 is 0.
- R5: Writing 0x5555 to offset 0x2 and then 0xAAAA as the next write to offset 0x2 reloads the countdown. If any other value is written between them, the sequence is aborted and the timeout falls at its original time.
- R6: The interrupt control register is at offset 0x6, and its bits 7:0 hold a lead L (with L < T). Its bit 14 flag sets when (T-L)*TICKS_PER_UNIT ticks have been counted since the load. Writing 1 to bit 14 clears the flag. irq is the flag ANDed with bit 15.
- R7: No tick is counted while wait_mode is high with control bit 7 set. The same holds for debug_mode with control bit 1, and for lowpwr_mode with control bit 0.
- R8: A timeout makes the reset-cause register read 0x0002. A soft_rst_evt pulse makes it read 0x0001.
- R9: Bit 0 of offset 0x8 reads back the last value written to it and resets to 0.
- R10: After a timeout the countdown reloads from T by itself. The next timeout follows another (T+1)*TICKS_PER_UNIT counted ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick_en | input | 1 | Slow time-base enable, one pulse per tick |
| wait_mode | input | 1 | System is in wait mode |
| debug_mode | input | 1 | System is halted for debug |
| lowpwr_mode | input | 1 | System is in low-power mode |
| soft_rst_evt | input | 1 | Pulse: a software reset took place |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write byte offset |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read byte offset |
| rd_data | output | 16 | Read data (combinational) |
| irq | output | 1 | Early-warning interrupt |
| sys_rst_req | output | 1 | Internal reset request pulse |
| ext_rst_out | output | 1 | External reset pulse |

## Verification
A remaining-unit count or a tick phase that is wrong shows up as a reset pulse, or an interrupt rise, that misses the tick count expected from the last load. In the randomized runs the mismatch is seen at the first unit boundary the fault disturbs, so within TICKS_PER_UNIT counted ticks. A broken unlock tracker shows up as a timeout that arrives at the wrong time after an aborted or a valid pair. A bad cause or flag latch is read back wrong on the next register read.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam int FIELD_W = 8;
  localparam int REG_W   = 16;
  localparam int ADDR_W  = 4;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_SVC  = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_ICR  = 4'h6;
  localparam logic [ADDR_W-1:0] OFS_MISC = 4'h8;

  localparam logic [REG_W-1:0] KEY_FIRST  = 16'h5555;
  localparam logic [REG_W-1:0] KEY_SECOND = 16'hAAAA;

  typedef struct packed {
    logic [FIELD_W-1:0] tmo;       // timeout units minus one
    logic               stop_wait; // freeze in wait mode
    logic               ext_mask;  // keep external reset quiet
    logic               int_mask;  // keep internal request quiet
    logic               ext_sel;   // drive external reset on timeout
    logic               run;       // sticky enable
    logic               stop_dbg;  // freeze in debug mode
    logic               stop_lp;   // freeze in low-power mode
  } ctrl_t;
endpackage

// File: rtl/guard_prescale.sv
module guard_prescale #(
  parameter int TICKS_PER_UNIT = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_ok,
  input  logic load,
  output logic unit_stb
);
  localparam int PW = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICKS_PER_UNIT - 1);

  logic [PW-1:0] phase_q, phase_d;
  logic          wrap;

  assign wrap     = (phase_q == LAST);
  assign unit_stb = count_ok && wrap && !load;

  always_comb begin
    phase_d = phase_q;
    if (load)          phase_d = '0;
    else if (count_ok) phase_d = wrap ? '0 : phase_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  // R3: the tick phase never leaves its unit window
  assert_phase_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST);
endmodule

// File: rtl/guard_countdown.sv
module guard_countdown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unit_stb,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [CNT_W-1:0] lead,
  output logic             flag_set,
  output logic             tout
);
  logic [CNT_W-1:0] remain_q, remain_d;
  logic             tout_d;

  always_comb begin
    remain_d = remain_q;
    tout_d   = 1'b0;
    flag_set = 1'b0;
    if (load) begin
      remain_d = load_val;
    end else if (unit_stb) begin
      if (remain_q == '0) begin
        remain_d = reload_val;
        tout_d   = 1'b1;
      end else begin
        remain_d = remain_q - CNT_W'(1);
        flag_set = ((remain_q - CNT_W'(1)) == lead);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      tout     <= 1'b0;
    end else begin
      remain_q <= remain_d;
      tout     <= tout_d;
    end
  end

  // R7: with no unit boundary and no load the remaining count is frozen
  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!unit_stb && !load) |=> $stable(remain_q));
endmodule

// File: rtl/guard_regs.sv
module guard_regs
  import guard_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [REG_W-1:0]   rd_data,
  input  logic               soft_rst_evt,
  input  logic               tout_evt,
  input  logic               flag_set,
  output ctrl_t              ctrl,
  output logic               irq_en,
  output logic               irq_flag,
  output logic [FIELD_W-1:0] lead,
  output logic               load,
  output logic [FIELD_W-1:0] load_val
);
  ctrl_t              ctrl_q, ctrl_d;
  logic               armed_q, armed_d;
  logic               ie_q, ie_d, flag_q, flag_d;
  logic [FIELD_W-1:0] lead_q, lead_d;
  logic [2:0]         cause_q, cause_d;   // {power-on, timeout, soft}
  logic               pde_q, pde_d;
  logic               hit_ctrl, hit_svc, hit_icr, hit_misc;
  logic               run_rise, svc_ok;

  assign hit_ctrl = wr_en && (wr_addr == OFS_CTRL);
  assign hit_svc  = wr_en && (wr_addr == OFS_SVC);
  assign hit_icr  = wr_en && (wr_addr == OFS_ICR);
  assign hit_misc = wr_en && (wr_addr == OFS_MISC);

  assign run_rise = hit_ctrl && wr_data[2] && !ctrl_q.run;
  assign svc_ok   = hit_svc && armed_q && (wr_data == KEY_SECOND);
  assign load     = run_rise || svc_ok;
  assign load_val = run_rise ? wr_data[15:8] : ctrl_q.tmo;

  always_comb begin
    ctrl_d  = ctrl_q;
    armed_d = armed_q;
    ie_d    = ie_q;
    lead_d  = lead_q;
    pde_d   = pde_q;
    cause_d = cause_q;
    if (hit_ctrl) begin
      ctrl_d = ctrl_t'({wr_data[15:8], wr_data[7], wr_data[5], wr_data[4],
                        wr_data[3], wr_data[2], wr_data[1], wr_data[0]});
      ctrl_d.run = ctrl_q.run || wr_data[2];
    end
    if (hit_svc)  armed_d = (wr_data == KEY_FIRST);
    if (hit_icr) begin
      ie_d   = wr_data[15];
      lead_d = wr_data[7:0];
    end
    if (hit_misc) pde_d = wr_data[0];
    flag_d = flag_set || (flag_q && !(hit_icr && wr_data[14]));
    if (tout_evt)          cause_d = 3'b010;
    else if (soft_rst_evt) cause_d = 3'b001;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      armed_q <= 1'b0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
      lead_q  <= '0;
      cause_q <= 3'b100;
      pde_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      armed_q <= armed_d;
      ie_q    <= ie_d;
      flag_q  <= flag_d;
      lead_q  <= lead_d;
      cause_q <= cause_d;
      pde_q   <= pde_d;
    end
  end

  always_comb begin
    case (rd_addr)
      OFS_CTRL: rd_data = {ctrl_q.tmo, ctrl_q.stop_wait, 1'b0, ctrl_q.ext_mask,
                           ctrl_q.int_mask, ctrl_q.ext_sel, ctrl_q.run,
                           ctrl_q.stop_dbg, ctrl_q.stop_lp};
      OFS_STAT: rd_data = {11'b0, cause_q[2], 2'b0, cause_q[1], cause_q[0]};
      OFS_ICR:  rd_data = {ie_q, flag_q, 6'b0, lead_q};
      OFS_MISC: rd_data = {15'b0, pde_q};
      default:  rd_data = '0;
    endcase
  end

  assign ctrl     = ctrl_q;
  assign irq_en   = ie_q;
  assign irq_flag = flag_q;
  assign lead     = lead_q;

  // R2: the run enable cannot be withdrawn
  assert_run_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.run |=> ctrl_q.run);

  // R8: exactly one reset cause is recorded at any time
  assert_cause_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(cause_q));
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_pkg::*;
#(
  parameter int TICKS_PER_UNIT = 16384
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wait_mode,
  input  logic              debug_mode,
  input  logic              lowpwr_mode,
  input  logic              soft_rst_evt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq,
  output logic              sys_rst_req,
  output logic              ext_rst_out
);
  logic [1:0]         rst_sync;
  logic               rst_core_n;
  ctrl_t              ctrl;
  logic               irq_en, irq_flag, load, flag_set, tout, unit_stb, count_ok;
  logic [FIELD_W-1:0] lead, load_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  assign count_ok = tick_en && ctrl.run
                 && !(ctrl.stop_wait && wait_mode)
                 && !(ctrl.stop_dbg  && debug_mode)
                 && !(ctrl.stop_lp   && lowpwr_mode);

  guard_regs u_regs (
    .clk(clk), .rst_n(rst_core_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .soft_rst_evt(soft_rst_evt), .tout_evt(tout), .flag_set(flag_set),
    .ctrl(ctrl), .irq_en(irq_en), .irq_flag(irq_flag), .lead(lead),
    .load(load), .load_val(load_val)
  );

  guard_prescale #(.TICKS_PER_UNIT(TICKS_PER_UNIT)) u_pre (
    .clk(clk), .rst_n(rst_core_n),
    .count_ok(count_ok), .load(load), .unit_stb(unit_stb)
  );

  guard_countdown #(.CNT_W(FIELD_W)) u_cnt (
    .clk(clk), .rst_n(rst_core_n),
    .unit_stb(unit_stb), .load(load), .load_val(load_val),
    .reload_val(ctrl.tmo), .lead(lead),
    .flag_set(flag_set), .tout(tout)
  );

  assign irq         = irq_flag && irq_en;
  assign sys_rst_req = tout && !ctrl.int_mask;
  assign ext_rst_out = tout && ctrl.ext_sel && !ctrl.ext_mask;

  generate
    if (TICKS_PER_UNIT > 1) begin : g_pulse_chk
      // R3: a timeout request lasts a single cycle
      assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
        sys_rst_req |=> !sys_rst_req);
    end
  endgenerate

  // R4: the external reset only accompanies a timeout
  assert_ext_with_timeout_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    ext_rst_out |-> $rose(tout));
endmodule

// File: tb/guard_timer_tb_top.sv
module guard_timer_tb_top;
  localparam int TPU = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b1;
  logic        wait_mode = 1'b0, debug_mode = 1'b0, lowpwr_mode = 1'b0;
  logic        soft_rst_evt = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = 4'h0;
  logic [15:0] wr_data = 16'h0;
  logic [3:0]  rd_addr = 4'h0;
  logic [15:0] rd_data;
  logic        irq, sys_rst_req, ext_rst_out;

  int errors = 0;
  int checks = 0;
  int tk = 0;
  int tk_mark = 0;
  logic m_wdw = 1'b0, m_dbg = 1'b0, m_lp = 1'b0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  guard_timer #(.TICKS_PER_UNIT(TPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .wait_mode(wait_mode), .debug_mode(debug_mode), .lowpwr_mode(lowpwr_mode),
    .soft_rst_evt(soft_rst_evt), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq(irq), .sys_rst_req(sys_rst_req), .ext_rst_out(ext_rst_out)
  );

  // counted-tick model from R7
  function automatic logic tick_counts(logic te, logic w, logic d, logic l);
    return te && !(m_wdw && w) && !(m_dbg && d) && !(m_lp && l);
  endfunction

  always @(posedge clk)
    if (tick_counts(tick_en, wait_mode, debug_mode, lowpwr_mode)) tk <= tk + 1;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic service();
    wr(4'h2, 16'h5555);
    wr(4'h2, 16'hAAAA);
    tk_mark = tk;
  endtask

  task automatic wait_pulse(output int got, output logic ext_seen);
    got = -1; ext_seen = 1'b0;
    for (int n = 0; n < 600; n++) begin
      @(posedge clk); #1;
      if (sys_rst_req) begin
        got = tk - tk_mark; ext_seen = ext_rst_out; tk_mark = tk;
        break;
      end
    end
  endtask

  task automatic wait_irq(output int got);
    got = -1;
    for (int n = 0; n < 600; n++) begin
      @(posedge clk); #1;
      if (irq) begin got = tk - tk_mark; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int   got;
    logic ext_seen;
    int   bad;
    void'($urandom(32'd20240611));

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;

    // R1 reset state
    rd(4'h4, v); chk(v == 16'h0010, "R1 cause after reset", v, 16'h0010);
    rd(4'h0, v); chk(v == 16'h0000, "R1 ctrl after reset", v, 16'h0000);
    chk(!irq && !sys_rst_req && !ext_rst_out, "R1 outputs low", {irq, sys_rst_req, ext_rst_out}, 0);

    // R9 misc storage
    wr(4'h8, 16'hFFFF); rd(4'h8, v); chk(v == 16'h0001, "R9 misc set", v, 1);
    wr(4'h8, 16'h0000); rd(4'h8, v); chk(v == 16'h0000, "R9 misc clear", v, 0);

    // R3/R4 first timeout: T=2, external reset selected
    wr(4'h0, 16'h020C); tk_mark = tk;
    wait_pulse(got, ext_seen);
    chk(got == 3 * TPU, "R3 timeout after enable", got, 3 * TPU);
    chk(ext_seen == 1'b1, "R4 ext pulse selected", ext_seen, 1);
    @(posedge clk); #1;
    rd(4'h4, v); chk(v == 16'h0002, "R8 cause after timeout", v, 16'h0002);

    // R10 free-running reload
    wait_pulse(got, ext_seen);
    chk(got == 3 * TPU, "R10 second timeout", got, 3 * TPU);

    // R2 sticky enable; ext deselected
    wr(4'h0, 16'h0200); rd(4'h0, v);
    chk(v == 16'h0204, "R2 enable sticky", v, 16'h0204);
    service();
    wait_pulse(got, ext_seen);
    chk(got == 3 * TPU, "R5 valid service reload", got, 3 * TPU);
    chk(ext_seen == 1'b0, "R4 ext pulse deselected", ext_seen, 0);

    // R5 aborted sequence: timeout keeps its original time
    wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
    wait_pulse(got, ext_seen);
    chk(got == 3 * TPU, "R5 aborted service ignored", got, 3 * TPU);

    // R6 early warning with L=0
    wr(4'h6, 16'hC000); service();
    wait_irq(got);
    chk(got == 2 * TPU, "R6 irq lead time", got, 2 * TPU);
    rd(4'h6, v); chk(v == 16'hC000, "R6 flag readback", v, 16'hC000);
    wr(4'h6, 16'hC000);
    chk(irq == 1'b0, "R6 write-one clears flag", irq, 0);
    wait_pulse(got, ext_seen);
    chk(got == 3 * TPU, "R3 timeout after irq", got, 3 * TPU);

    // R6 flag sets with interrupt disabled, L=1
    wr(4'h6, 16'h4001); service();
    repeat (6) @(posedge clk); #1;
    rd(4'h6, v); chk(v == 16'h4001, "R6 flag without enable", v, 16'h4001);
    chk(irq == 1'b0, "R6 irq gated by enable", irq, 0);

    // R3/R4 masked outputs, R8 soft cause
    wr(4'h0, 16'h0238); service();
    @(negedge clk); soft_rst_evt = 1'b1;
    @(posedge clk); #1; soft_rst_evt = 1'b0;
    rd(4'h4, v); chk(v == 16'h0001, "R8 soft cause", v, 16'h0001);
    bad = 0;
    for (int n = 0; n < 15; n++) begin
      @(posedge clk); #1;
      if (sys_rst_req || ext_rst_out) bad++;
    end
    chk(bad == 0, "R3 R4 masked reset outputs", bad, 0);
    rd(4'h4, v); chk(v == 16'h0002, "R8 masked timeout recorded", v, 16'h0002);

    // R7 wait-mode freeze
    wr(4'h0, 16'h0280); m_wdw = 1'b1; service();
    @(negedge clk); wait_mode = 1'b1;
    bad = 0;
    for (int n = 0; n < 40; n++) begin
      @(posedge clk); #1;
      if (sys_rst_req) bad++;
    end
    chk(bad == 0, "R7 frozen in wait mode", bad, 0);
    @(negedge clk); wait_mode = 1'b0;
    wait_pulse(got, ext_seen);
    chk(got == 3 * TPU, "R7 resumes after wait mode", got, 3 * TPU);

    // random phase: R3 R4 R6 R7
    for (int it = 0; it < 30; it++) begin
      int t, l, lim_t, lim_i;
      logic b7, b5, b3, b1, b0, found;
      t  = 1 + int'($urandom % 5);
      l  = int'($urandom % t);
      b7 = 1'($urandom); b5 = 1'($urandom); b3 = 1'($urandom);
      b1 = 1'($urandom); b0 = 1'($urandom);
      tick_en = 1'b0; wait_mode = 1'b0; debug_mode = 1'b0; lowpwr_mode = 1'b0;
      wr(4'h0, {8'(t), b7, 1'b0, b5, 1'b0, b3, 1'b1, b1, b0});
      m_wdw = b7; m_dbg = b1; m_lp = b0;
      wr(4'h6, 16'hC000 | 16'(l));
      service();
      lim_t = (t + 1) * TPU;
      lim_i = (t - l) * TPU;
      bad = 0; found = 1'b0;
      for (int n = 0; n < 3000; n++) begin
        int eff;
        @(negedge clk);
        tick_en     = 1'($urandom % 2);
        wait_mode   = ($urandom % 4) == 0;
        debug_mode  = ($urandom % 4) == 0;
        lowpwr_mode = ($urandom % 4) == 0;
        @(posedge clk); #1;
        eff = tk - tk_mark;
        if (eff == lim_t) begin
          if (!sys_rst_req) bad++;
          if (ext_rst_out != (b3 && !b5)) bad++;
          found = 1'b1;
          break;
        end
        if (sys_rst_req) bad++;
        if (irq != (eff >= lim_i)) bad++;
      end
      chk(found && bad == 0, "R3 R4 R6 R7 random run", bad, 0);
    end
    tick_en = 1'b1; wait_mode = 1'b0; debug_mode = 1'b0; lowpwr_mode = 1'b0;

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule